// File: doc/BRIEF.md
# Program Counter and Branch Sequencer

This block owns the program counter of a small 8-bit register machine whose instructions are two bytes wide and whose addresses are 12 bits. An instruction decoder outside the block presents one branch-class operation at a time. Each operation carries a kind code, two register numbers, an 8-bit immediate and a 12-bit address. The decoder also supplies the full register file contents and the state of 16 keys. The block accepts the operation when `ready_o` is high and retires it by loading a new PC. It pulses `op_done_o` when the new PC becomes visible.

Calls and returns keep a stack of 16-bit words in byte-addressed shared memory, reached through a single byte-wide port with one cycle of read latency. The stack grows toward lower addresses, and each word takes two byte accesses with the high byte first. The block also stops on its own. A jump whose target is the instruction itself raises a halt flag that holds until reset. A retired PC that matches any enabled breakpoint entry raises a pause flag, which `resume_i` clears. While either flag is set, no operation is accepted.

Top module: `pc_branch_unit`

## Requirements
- R1: After reset the PC reads 0x200, the stack pointer reads 0xEFE, halt and pause are low and `ready_o` is high.
- R2: `op_kind_i` is encoded as follows: 0 advance, 1 jump, 2 indexed jump, 3 call, 4 return, 5 skip if register equals immediate, 6 skip if register differs from immediate, 7 skip if registers equal, 8 skip if registers differ, 9 skip if key pressed, 10 skip if key released. An accepted advance loads PC+2 on the next clock edge, wrapping modulo 4096.
- R3: Kinds 5 and 6 compare register `op_rx_i` with `op_imm_i`. When the condition holds the PC moves by 4, otherwise by 2.
- R4: Kinds 7 and 8 compare registers `op_rx_i` and `op_ry_i`. When the condition holds the PC moves by 4, otherwise by 2.
- R5: Kinds 9 and 10 select key bit `keys_i[v]`, where v is the low four bits of register `op_rx_i`. Kind 9 skips when that bit is 1 and kind 10 skips when it is 0.
- R6: A jump loads `op_addr_i`. If `op_addr_i` equals the current PC, `halt_o` rises and stays high until reset, and `ready_o` stays low.
- R7: An indexed jump loads `op_addr_i` plus a register value, wrapped to 12 bits. The register is number 0 when `idx_from_addr_i` is 0, and number `op_addr_i[11:8]` when it is 1.
- R8: A call writes byte {0, (PC+2)[11:8]} to the address held in SP. On the next cycle it writes (PC+2)[7:0] to SP+1. It then lowers SP by 2 and loads `op_addr_i`, retiring two cycles after acceptance.
- R9: A return raises SP by 2 on acceptance. It then reads the bytes at SP and SP+1 and loads PC = {first[3:0], second}, retiring three cycles after acceptance.
- R10: When a retired PC equals a breakpoint entry whose valid bit is set, `pause_o` rises and `ready_o` drops. A cycle with `resume_i` high clears `pause_o`. Entries whose valid bit is clear never cause a pause.
- R11: While halted or paused, `op_valid_i` is ignored: PC and SP do not change.
- R12: `op_done_o` is high for the cycle in which the retired PC first appears on `pc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | Operation present |
| op_kind_i | input | 4 | Operation kind code |
| op_rx_i | input | 4 | First register number |
| op_ry_i | input | 4 | Second register number |
| op_imm_i | input | 8 | Immediate byte |
| op_addr_i | input | 12 | Target address |
| regs_i | input | 128 | Register file, register n in bits 8n+7:8n |
| keys_i | input | 16 | Key pressed flags |
| idx_from_addr_i | input | 1 | Indexed jump takes its register number from the address |
| bp_addr_i | input | 48 | Breakpoint addresses, entry n in bits 12n+11:12n |
| bp_valid_i | input | 4 | Breakpoint enables |
| resume_i | input | 1 | Clear pause |
| mem_we_o | output | 1 | Memory byte write |
| mem_re_o | output | 1 | Memory byte read |
| mem_addr_o | output | 12 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write byte |
| mem_rdata_i | input | 8 | Read byte, valid the cycle after a read |
| ready_o | output | 1 | Operation will be accepted |
| op_done_o | output | 1 | Operation retired |
| pc_o | output | 12 | Program counter |
| sp_o | output | 12 | Stack pointer |
| halt_o | output | 1 | Jump to self seen |
| pause_o | output | 1 | Breakpoint hit |

## Verification
The assertions assume that the decoder holds `op_valid_i` low or keeps the operation stable while `ready_o` is low. They also assume that memory returns read data exactly one cycle after `mem_re_o`, and that `resume_i` is raised only while paused. The stimulus keeps to these conditions. It waits for `ready_o` before presenting each operation, models memory as a synchronous byte array, and pulses `resume_i` once after the breakpoint stop. The only deliberate exception is the ignored-operation test: there the bench holds `op_valid_i` high while the block is paused or halted, to show that PC and SP do not move.

// File: rtl/pcbu_pkg.sv
package pcbu_pkg;
  localparam int unsigned ADDR_W     = 12;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned WORD_W     = 2 * DATA_W;
  localparam int unsigned NREG       = 16;
  localparam int unsigned NKEY       = 16;
  localparam int unsigned REG_IDX_W  = $clog2(NREG);
  localparam int unsigned KEY_IDX_W  = $clog2(NKEY);
  localparam int unsigned INSN_BYTES = 2;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  typedef enum logic [3:0] {
    BR_ADV   = 4'd0,
    BR_JMP   = 4'd1,
    BR_JMPX  = 4'd2,
    BR_CALL  = 4'd3,
    BR_RET   = 4'd4,
    BR_SEQI  = 4'd5,
    BR_SNEI  = 4'd6,
    BR_SEQR  = 4'd7,
    BR_SNER  = 4'd8,
    BR_SKEY  = 4'd9,
    BR_SNKEY = 4'd10
  } br_op_e;

  typedef enum logic [1:0] {
    SEQ_RUN,
    SEQ_PUSH,
    SEQ_POP
  } seq_st_e;

  typedef enum logic [2:0] {
    STK_IDLE,
    STK_W_HI,
    STK_W_LO,
    STK_R_HI,
    STK_R_LO,
    STK_R_END
  } stk_st_e;

  function automatic addr_t addr_add(input addr_t a, input addr_t b);
    return a + b;
  endfunction

  function automatic addr_t pc_advance(input addr_t pc);
    return addr_add(pc, addr_t'(INSN_BYTES));
  endfunction

  function automatic addr_t idx_target(input addr_t base, input byte_t off);
    return addr_add(base, addr_t'(off));
  endfunction
endpackage

// File: rtl/pcbu_skip_eval.sv
module pcbu_skip_eval import pcbu_pkg::*; (
  input  br_op_e          op_i,
  input  byte_t           rx_val_i,
  input  byte_t           ry_val_i,
  input  byte_t           imm_i,
  input  logic [NKEY-1:0] keys_i,
  output logic            skip_o
);
  logic [KEY_IDX_W-1:0] key_sel;
  logic                 key_down;
  logic                 imm_eq;
  logic                 reg_eq;

  assign key_sel  = rx_val_i[KEY_IDX_W-1:0];
  assign key_down = keys_i[key_sel];
  assign imm_eq   = (rx_val_i == imm_i);
  assign reg_eq   = (rx_val_i == ry_val_i);

  always_comb begin
    skip_o = 1'b0;
    unique case (op_i)
      BR_SEQI:  skip_o = imm_eq;
      BR_SNEI:  skip_o = !imm_eq;
      BR_SEQR:  skip_o = reg_eq;
      BR_SNER:  skip_o = !reg_eq;
      BR_SKEY:  skip_o = key_down;
      BR_SNKEY: skip_o = !key_down;
      default:  skip_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pcbu_bp_match.sv
module pcbu_bp_match import pcbu_pkg::*; #(
  parameter int unsigned NBP = 4
) (
  input  addr_t                  addr_i,
  input  logic [NBP*ADDR_W-1:0]  bp_addr_i,
  input  logic [NBP-1:0]         bp_valid_i,
  output logic                   hit_o
);
  logic [NBP-1:0] entry_hit;

  for (genvar g = 0; g < NBP; g++) begin : g_entry
    assign entry_hit[g] = bp_valid_i[g] && (bp_addr_i[g*ADDR_W +: ADDR_W] == addr_i);
  end

  assign hit_o = |entry_hit;
endmodule

// File: rtl/pcbu_stack_port.sv
module pcbu_stack_port import pcbu_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push_i,
  input  logic  pop_i,
  input  addr_t base_i,
  input  addr_t push_addr_i,
  input  byte_t mem_rdata_i,
  output logic  mem_we_o,
  output logic  mem_re_o,
  output addr_t mem_addr_o,
  output byte_t mem_wdata_o,
  output logic  done_o,
  output addr_t pop_addr_o
);
  stk_st_e             st_q;
  addr_t               base_q;
  logic [WORD_W-1:0]   word_q;
  byte_t               hi_q;
  addr_t               base_nx;

  assign base_nx = addr_add(base_q, addr_t'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= STK_IDLE;
      base_q <= '0;
      word_q <= '0;
      hi_q   <= '0;
    end else begin
      unique case (st_q)
        STK_IDLE: begin
          if (push_i) begin
            st_q   <= STK_W_HI;
            base_q <= base_i;
            word_q <= WORD_W'(push_addr_i);
          end else if (pop_i) begin
            st_q   <= STK_R_HI;
            base_q <= base_i;
          end
        end
        STK_W_HI:  st_q <= STK_W_LO;
        STK_W_LO:  st_q <= STK_IDLE;
        STK_R_HI:  st_q <= STK_R_LO;
        STK_R_LO: begin
          hi_q <= mem_rdata_i;
          st_q <= STK_R_END;
        end
        STK_R_END: st_q <= STK_IDLE;
        default:   st_q <= STK_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_we_o    = 1'b0;
    mem_re_o    = 1'b0;
    mem_addr_o  = base_q;
    mem_wdata_o = '0;
    done_o      = 1'b0;
    unique case (st_q)
      STK_W_HI: begin
        mem_we_o    = 1'b1;
        mem_wdata_o = word_q[WORD_W-1 -: DATA_W];
      end
      STK_W_LO: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = base_nx;
        mem_wdata_o = word_q[DATA_W-1:0];
        done_o      = 1'b1;
      end
      STK_R_HI: mem_re_o = 1'b1;
      STK_R_LO: begin
        mem_re_o   = 1'b1;
        mem_addr_o = base_nx;
      end
      STK_R_END: done_o = 1'b1;
      default: ;
    endcase
  end

  assign pop_addr_o = addr_t'({hi_q, mem_rdata_i});

  // R8: the high-byte write is followed by the low-byte write one address up
  assert_push_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && !done_o) |=> (mem_we_o && mem_addr_o == addr_add($past(mem_addr_o), addr_t'(1))));

  // R9: the port never reads and writes in the same cycle
  assert_port_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o));

  // R9: each read is followed by another read or by completion
  assert_pop_seq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re_o |=> (mem_re_o || done_o));
endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit import pcbu_pkg::*; #(
  parameter int unsigned NBP      = 4,
  parameter addr_t       PC_RESET = 12'h200,
  parameter addr_t       SP_RESET = 12'hEFE
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    op_valid_i,
  input  logic [3:0]              op_kind_i,
  input  logic [REG_IDX_W-1:0]    op_rx_i,
  input  logic [REG_IDX_W-1:0]    op_ry_i,
  input  logic [DATA_W-1:0]       op_imm_i,
  input  logic [ADDR_W-1:0]       op_addr_i,
  input  logic [NREG*DATA_W-1:0]  regs_i,
  input  logic [NKEY-1:0]         keys_i,
  input  logic                    idx_from_addr_i,
  input  logic [NBP*ADDR_W-1:0]   bp_addr_i,
  input  logic [NBP-1:0]          bp_valid_i,
  input  logic                    resume_i,
  output logic                    mem_we_o,
  output logic                    mem_re_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic [DATA_W-1:0]       mem_wdata_o,
  input  logic [DATA_W-1:0]       mem_rdata_i,
  output logic                    ready_o,
  output logic                    op_done_o,
  output logic [ADDR_W-1:0]       pc_o,
  output logic [ADDR_W-1:0]       sp_o,
  output logic                    halt_o,
  output logic                    pause_o
);
  localparam addr_t SP_STEP = addr_t'(WORD_W / DATA_W);

  br_op_e  op;
  seq_st_e st_q;
  addr_t   pc_q, sp_q, tgt_q;
  logic    halt_q, pause_q, done_q;

  byte_t                rx_val, ry_val, jx_off;
  logic [REG_IDX_W-1:0] jx_idx;
  addr_t                pc_adv, direct_pc, new_pc, pop_addr;
  logic                 skip, accept, is_stack_op, retire_simple, retire;
  logic                 self_jump, bp_hit, stk_done;
  logic                 push_go, pop_go;
  addr_t                stk_base;

  assign op     = br_op_e'(op_kind_i);
  assign rx_val = regs_i[op_rx_i*DATA_W +: DATA_W];
  assign ry_val = regs_i[op_ry_i*DATA_W +: DATA_W];
  assign jx_idx = idx_from_addr_i ? op_addr_i[ADDR_W-1 -: REG_IDX_W] : '0;
  assign jx_off = regs_i[jx_idx*DATA_W +: DATA_W];
  assign pc_adv = pc_advance(pc_q);

  pcbu_skip_eval u_skip (
    .op_i     (op),
    .rx_val_i (rx_val),
    .ry_val_i (ry_val),
    .imm_i    (op_imm_i),
    .keys_i   (keys_i),
    .skip_o   (skip)
  );

  always_comb begin
    unique case (op)
      BR_JMP:  direct_pc = op_addr_i;
      BR_JMPX: direct_pc = idx_target(op_addr_i, jx_off);
      BR_SEQI, BR_SNEI, BR_SEQR, BR_SNER, BR_SKEY, BR_SNKEY:
               direct_pc = skip ? pc_advance(pc_adv) : pc_adv;
      default: direct_pc = pc_adv;
    endcase
  end

  assign ready_o       = (st_q == SEQ_RUN) && !halt_q && !pause_q;
  assign accept        = op_valid_i && ready_o;
  assign is_stack_op   = (op == BR_CALL) || (op == BR_RET);
  assign retire_simple = accept && !is_stack_op;
  assign push_go       = accept && (op == BR_CALL);
  assign pop_go        = accept && (op == BR_RET);
  assign stk_base      = push_go ? sp_q : addr_add(sp_q, SP_STEP);
  assign self_jump     = (op == BR_JMP) && (pc_advance(op_addr_i) == pc_adv);

  pcbu_stack_port u_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_go),
    .pop_i       (pop_go),
    .base_i      (stk_base),
    .push_addr_i (pc_adv),
    .mem_rdata_i (mem_rdata_i),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .done_o      (stk_done),
    .pop_addr_o  (pop_addr)
  );

  assign retire = retire_simple || stk_done;

  always_comb begin
    if (retire_simple)          new_pc = direct_pc;
    else if (st_q == SEQ_PUSH)  new_pc = tgt_q;
    else                        new_pc = pop_addr;
  end

  pcbu_bp_match #(.NBP(NBP)) u_bp (
    .addr_i     (new_pc),
    .bp_addr_i  (bp_addr_i),
    .bp_valid_i (bp_valid_i),
    .hit_o      (bp_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= SEQ_RUN;
      pc_q    <= PC_RESET;
      sp_q    <= SP_RESET;
      tgt_q   <= '0;
      halt_q  <= 1'b0;
      pause_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= retire;
      if (resume_i) pause_q <= 1'b0;
      if (retire) begin
        pc_q <= new_pc;
        if (bp_hit) pause_q <= 1'b1;
      end
      if (retire_simple && self_jump) halt_q <= 1'b1;
      if (push_go) begin
        st_q  <= SEQ_PUSH;
        tgt_q <= op_addr_i;
      end
      if (pop_go) begin
        st_q <= SEQ_POP;
        sp_q <= addr_add(sp_q, SP_STEP);
      end
      if (stk_done) begin
        st_q <= SEQ_RUN;
        if (st_q == SEQ_PUSH) sp_q <= sp_q - SP_STEP;
      end
    end
  end

  assign pc_o      = pc_q;
  assign sp_o      = sp_q;
  assign halt_o    = halt_q;
  assign pause_o   = pause_q;
  assign op_done_o = done_q;

  // R2: an accepted advance moves the PC by one instruction
  assert_adv_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == BR_ADV) |=> (pc_o == pc_advance($past(pc_o))));

  // R6: halt, once raised, stays raised
  assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |=> halt_o);

  // R8: a completed push lowers the stack pointer by one word
  assert_call_sp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_done && st_q == SEQ_PUSH) |=> (sp_o == $past(sp_o) - SP_STEP));

  // R9: an accepted return raises the stack pointer by one word
  assert_ret_sp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pop_go |=> (sp_o == addr_add($past(sp_o), SP_STEP)));

  // R10: pause holds until resume
  assert_pause_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_o && !resume_i) |=> pause_o);

  // R11: a stopped sequencer leaves the PC alone
  assert_stopped_pc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_RUN && (halt_o || pause_o)) |=> $stable(pc_o));

  // R12: the done strobe follows a change of sequencer work, never an idle stall
  assert_done_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid_i && st_q == SEQ_RUN) |=> !op_done_o);
endmodule

// File: tb/pc_branch_unit_tb.sv
`timescale 1ns/1ps
module pc_branch_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_valid = 1'b0;
  logic [3:0]   op_kind = '0, op_rx = '0, op_ry = '0;
  logic [7:0]   op_imm = '0;
  logic [11:0]  op_addr = '0;
  logic [127:0] regs;
  logic [15:0]  keys = 16'h0080;
  logic         idx_hi = 1'b0;
  logic [47:0]  bp_bus;
  logic [3:0]   bp_v;
  logic         resume = 1'b0;
  logic         mem_we, mem_re, ready, op_done, halt, pause;
  logic [11:0]  mem_addr, pc, sp;
  logic [7:0]   mem_wdata, mem_rdata;

  logic [7:0]  rv [16];
  logic [11:0] bpa [4];
  logic [7:0]  mem [0:4095];
  logic [7:0]  m_mem [0:4095];
  logic [11:0] m_pc, m_sp;
  logic        m_halt, m_pause;
  logic        cmp_en = 1'b0;
  logic        finished = 1'b0;
  string       cur_tag = "R1";
  int          n_cmp = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 16; i++) regs[i*8 +: 8] = rv[i];
    for (int i = 0; i < 4; i++) bp_bus[i*12 +: 12] = bpa[i];
  end

  pc_branch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid), .op_kind_i(op_kind),
    .op_rx_i(op_rx), .op_ry_i(op_ry), .op_imm_i(op_imm), .op_addr_i(op_addr),
    .regs_i(regs), .keys_i(keys), .idx_from_addr_i(idx_hi),
    .bp_addr_i(bp_bus), .bp_valid_i(bp_v), .resume_i(resume),
    .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .ready_o(ready), .op_done_o(op_done), .pc_o(pc), .sp_o(sp),
    .halt_o(halt), .pause_o(pause)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      check(pc == m_pc, cur_tag, "pc", 32'(pc), 32'(m_pc));
      check(sp == m_sp, cur_tag, "sp", 32'(sp), 32'(m_sp));
      check(halt == m_halt, cur_tag, "halt", 32'(halt), 32'(m_halt));
      check(pause == m_pause, cur_tag, "pause", 32'(pause), 32'(m_pause));
    end
  end

  task automatic do_op(input int kind, input logic [3:0] x, input logic [3:0] y,
                       input logic [7:0] imm, input logic [11:0] adr,
                       input logic quirk, input string tag);
    logic [11:0] adv, np, a1;
    logic        sk, hl;
    int          guard;
    guard = 0;
    while (!ready && guard < 50) begin
      @(negedge clk);
      guard++;
    end
    cur_tag = tag;
    op_kind = 4'(kind); op_rx = x; op_ry = y; op_imm = imm; op_addr = adr; idx_hi = quirk;
    op_valid = 1'b1;
    adv = m_pc + 12'd2;
    sk = 1'b0;
    hl = 1'b0;
    np = adv;
    case (kind)
      1: begin np = adr; hl = (adr == m_pc); end
      2: np = adr + {4'h0, rv[quirk ? int'(adr[11:8]) : 0]};
      5: sk = (rv[x] == imm);
      6: sk = (rv[x] != imm);
      7: sk = (rv[x] == rv[y]);
      8: sk = (rv[x] != rv[y]);
      9: sk = keys[rv[x][3:0]];
      10: sk = !keys[rv[x][3:0]];
      default: ;
    endcase
    if (sk) np = adv + 12'd2;
    @(posedge clk);
    #1 op_valid = 1'b0;
    if (kind == 3) begin
      a1 = m_sp + 12'd1;
      m_mem[m_sp] = {4'h0, adv[11:8]};
      m_mem[a1] = adv[7:0];
      repeat (2) @(posedge clk);
      #1 m_sp = m_sp - 12'd2;
      np = adr;
    end else if (kind == 4) begin
      m_sp = m_sp + 12'd2;
      a1 = m_sp + 12'd1;
      repeat (3) @(posedge clk);
      #1 np = {m_mem[m_sp][3:0], m_mem[a1]};
    end
    m_pc = np;
    if (hl) m_halt = 1'b1;
    for (int i = 0; i < 4; i++) if (bp_v[i] && bpa[i] == np) m_pause = 1'b1;
    @(negedge clk);
    check(op_done == 1'b1, "R12", "op_done", 32'(op_done), 32'd1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) rv[i] = 8'h00;
    rv[0] = 8'h10; rv[1] = 8'h33; rv[2] = 8'h33; rv[3] = 8'h44;
    rv[5] = 8'h07; rv[10] = 8'h05; rv[15] = 8'hFF;
    bpa[0] = 12'h350; bpa[1] = 12'h360; bpa[2] = 12'h000; bpa[3] = 12'h000;
    bp_v = 4'b0001;
    for (int i = 0; i < 4096; i++) begin
      mem[i] = 8'h00;
      m_mem[i] = 8'h00;
    end
    mem[12'hF00] = 8'h03; mem[12'hF01] = 8'h4A;
    m_mem[12'hF00] = 8'h03; m_mem[12'hF01] = 8'h4A;
    m_pc = 12'h200; m_sp = 12'hEFE; m_halt = 1'b0; m_pause = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(pc == 12'h200, "R1", "reset pc", 32'(pc), 32'h200);
    check(sp == 12'hEFE, "R1", "reset sp", 32'(sp), 32'hEFE);
    check(!halt && !pause, "R1", "reset flags", {30'd0, halt, pause}, 32'd0);
    check(ready == 1'b1, "R1", "reset ready", 32'(ready), 32'd1);
    cmp_en = 1'b1;

    do_op(0, 0, 0, 0, 0, 0, "R2");
    do_op(5, 1, 0, 8'h33, 0, 0, "R3");
    do_op(5, 1, 0, 8'h34, 0, 0, "R3");
    do_op(6, 1, 0, 8'h34, 0, 0, "R3");
    do_op(6, 1, 0, 8'h33, 0, 0, "R3");
    do_op(7, 1, 2, 0, 0, 0, "R4");
    do_op(8, 1, 2, 0, 0, 0, "R4");
    do_op(8, 1, 3, 0, 0, 0, "R4");
    do_op(7, 1, 3, 0, 0, 0, "R4");
    do_op(9, 5, 0, 0, 0, 0, "R5");
    do_op(10, 5, 0, 0, 0, 0, "R5");
    do_op(9, 3, 0, 0, 0, 0, "R5");
    do_op(10, 3, 0, 0, 0, 0, "R5");
    check(pc == 12'h226, "R5", "pc after skips", 32'(pc), 32'h226);
    do_op(1, 0, 0, 0, 12'h300, 0, "R6");
    do_op(2, 0, 0, 0, 12'h120, 0, "R7");
    check(pc == 12'h130, "R7", "indexed via r0", 32'(pc), 32'h130);
    do_op(2, 0, 0, 0, 12'hA20, 1, "R7");
    check(pc == 12'hA25, "R7", "indexed via addr nibble", 32'(pc), 32'hA25);
    do_op(2, 0, 0, 0, 12'hFF8, 0, "R7");
    do_op(1, 0, 0, 0, 12'hFFE, 0, "R6");
    do_op(0, 0, 0, 0, 0, 0, "R2");
    check(pc == 12'h000, "R2", "wrap", 32'(pc), 32'h000);
    do_op(3, 0, 0, 0, 12'h400, 0, "R8");
    check(mem[12'hEFE] == 8'h00 && mem[12'hEFF] == 8'h02, "R8", "pushed word",
          {16'd0, mem[12'hEFE], mem[12'hEFF]}, 32'h0002);
    do_op(3, 0, 0, 0, 12'h5AB, 0, "R8");
    check(mem[12'hEFC] == 8'h04 && mem[12'hEFD] == 8'h02, "R8", "pushed word",
          {16'd0, mem[12'hEFC], mem[12'hEFD]}, 32'h0402);
    do_op(4, 0, 0, 0, 0, 0, "R9");
    check(pc == 12'h402, "R9", "return pc", 32'(pc), 32'h402);
    do_op(4, 0, 0, 0, 0, 0, "R9");
    do_op(4, 0, 0, 0, 0, 0, "R9");
    check(pc == 12'h34A, "R9", "return preloaded", 32'(pc), 32'h34A);
    do_op(0, 0, 0, 0, 0, 0, "R10");
    do_op(0, 0, 0, 0, 0, 0, "R10");
    do_op(0, 0, 0, 0, 0, 0, "R10");
    check(pause == 1'b1 && ready == 1'b0, "R10", "paused", {30'd0, pause, ready}, 32'd2);
    cur_tag = "R11";
    op_kind = 4'd0; op_valid = 1'b1;
    repeat (3) @(negedge clk);
    op_valid = 1'b0;
    check(pc == 12'h350, "R11", "pc while paused", 32'(pc), 32'h350);
    cur_tag = "R10";
    resume = 1'b1;
    @(posedge clk);
    #1 resume = 1'b0;
    m_pause = 1'b0;
    @(negedge clk);
    check(ready == 1'b1, "R10", "ready after resume", 32'(ready), 32'd1);
    do_op(1, 0, 0, 0, 12'h360, 0, "R10");
    check(pause == 1'b0, "R10", "invalid entry", 32'(pause), 32'd0);
    do_op(1, 0, 0, 0, 12'h360, 0, "R6");
    check(halt == 1'b1 && ready == 1'b0, "R6", "self jump halt", {30'd0, halt, ready}, 32'd2);
    cur_tag = "R11";
    op_kind = 4'd3; op_addr = 12'h123; op_valid = 1'b1;
    repeat (4) @(negedge clk);
    op_valid = 1'b0;
    check(pc == 12'h360 && sp == 12'hF00, "R11", "pc/sp while halted",
          {8'd0, pc, sp}, {8'd0, 12'h360, 12'hF00});
    repeat (2) @(negedge clk);
    cmp_en = 1'b0;
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule